// File: doc/BRIEF.md
# NOR Flash Command State Machine

This block is the device-side command interpreter of a byte-wide parallel NOR flash. It watches single-cycle bus writes, recognises the unlock / set-up / final-code sequences for byte program, whole-chip erase and sector erase, and then runs a stand-in embedded operation against a small internal array. Each operation lasts a configurable number of clock cycles. While an operation is pending or busy, data reads return a status byte in place of array data. After a sector-erase command, a timed accept window collects further sector addresses into an erase set before the erase begins.

The array is deliberately tiny. Each sector keeps `2**OFS_W` bytes, and a byte is selected by the sector bits (the top `SEC_W` address bits) and the low `OFS_W` address bits. All other address bits alias. Reads are registered, and `rdata` holds the result of the read strobed on the previous clock edge.

Top module: `nor_flash_csm`

## Requirements
- R1: After reset every array byte reads 0xFF and the block is in array-read mode.
- R2: The writes AA at address 0x555, then 55 at 0x2AA, then A0 at 0x555, followed by one write of data D at address A, program byte A. Only addr[10:0] is compared for the command addresses.
- R3: A program stores the old byte AND D, so no bit can go from 0 to 1. While that program is busy, status bit 5 reads 1 if D has a 1 where the old byte has a 0, and reads 0 otherwise.
- R4: A write that does not match the next expected cycle returns the decoder to array-read mode. The rest of a broken sequence then has no effect.
- R5: For a program, status bit 7 reads as the inverse of D bit 7, bit 6 flips on every read, bit 3 reads 0, bit 2 reads 1, and bits 4, 1 and 0 read 0. The status lasts PROG_CYC clock edges after the data write edge, and array data returns on the following read.
- R6: While a program is busy, all writes are ignored.
- R7: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 erases the whole array with no accept window. The erase first sets the target bytes to 0x00 for ERASE_CYC cycles, then sets them to 0xFF for ERASE_CYC cycles. While erasing, status bit 3 reads 1 and bit 7 reads 0.
- R8: Replacing the final cycle with data 30 at any address in sector S opens an accept window of WIN_CYC cycles with S in the erase set. Status bit 3 reads 0 in the window, and the erase starts when the window runs out.
- R9: Inside the window, each write of data 30 adds the sector of its address to the set and restarts the window. Only sectors in the set are erased.
- R10: Inside the window, a write of any data other than 30 or B0 empties the set and returns to array-read mode at once.
- R11: During an erase, a write of B0 suspends it. While suspended, reads return array data and the erase makes no progress. A write of 30 resumes the erase, and every other write during an erase or a suspension is ignored.
- R12: In the window and during an erase, status bit 2 flips with bit 6 on reads of a sector in the erase set, and reads 1 for other sectors.
- R13: When an operation completes, the block returns to array-read mode. Address bits outside the sector and offset fields do not select a different byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data / command code |
| rdata | output | 8 | Registered read data or status byte |

## Verification
A decoder stuck in a mid-sequence state shows up on the very next read: a program or erase lands where none was asked for, or one that was asked for never happens. A wrong engine state shows up on the first status read, through bit 3 (window or erasing) and bit 7 (program polarity). A wrong erase set or suspend state only appears after the operation ends, when a sector that should have been erased still holds data or the reverse, so the bench reads several sectors back after every erase. A counter off by one shows in the exact read where status gives way to array data.

// File: rtl/nor_csm_pkg.sv
package nor_csm_pkg;

    localparam logic [7:0]  CODE_UNLK1 = 8'hAA;
    localparam logic [7:0]  CODE_UNLK2 = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERS   = 8'h80;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_SUSP  = 8'hB0;
    localparam logic [10:0] ADR_FIRST  = 11'h555;
    localparam logic [10:0] ADR_SECOND = 11'h2AA;

    typedef enum logic [2:0] {
        D_IDLE, D_U1, D_U2, D_PADDR, D_E3, D_E4, D_E5
    } dec_st_t;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_WIN, E_ERASE, E_SUSP
    } eng_st_t;

    typedef enum logic {
        PH_ZERO, PH_ONES
    } ers_ph_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
    } cmd_ev_t;

    function automatic logic cyc_is(input logic [10:0] a, input logic [7:0] d,
                                    input logic [10:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_csm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [10:0] adr_lo,
    input  logic [7:0]  wdata,
    output cmd_ev_t     ev
);
    dec_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        ev    = '0;
        if (wr_en) begin
            case (st)
                D_IDLE:  st_nx = cyc_is(adr_lo, wdata, ADR_FIRST, CODE_UNLK1) ? D_U1 : D_IDLE;
                D_U1:    st_nx = cyc_is(adr_lo, wdata, ADR_SECOND, CODE_UNLK2) ? D_U2 : D_IDLE;
                D_U2: begin
                    if (cyc_is(adr_lo, wdata, ADR_FIRST, CODE_PROG))
                        st_nx = D_PADDR;
                    else if (cyc_is(adr_lo, wdata, ADR_FIRST, CODE_ERS))
                        st_nx = D_E3;
                    else
                        st_nx = D_IDLE;
                end
                D_PADDR: begin
                    ev.prog = 1'b1;
                    st_nx   = D_IDLE;
                end
                D_E3:    st_nx = cyc_is(adr_lo, wdata, ADR_FIRST, CODE_UNLK1) ? D_E4 : D_IDLE;
                D_E4:    st_nx = cyc_is(adr_lo, wdata, ADR_SECOND, CODE_UNLK2) ? D_E5 : D_IDLE;
                D_E5: begin
                    st_nx = D_IDLE;
                    if (cyc_is(adr_lo, wdata, ADR_FIRST, CODE_CHIP))
                        ev.chip = 1'b1;
                    else if (wdata == CODE_SECT)
                        ev.sect = 1'b1;
                end
                default: st_nx = D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= D_IDLE;
        else     st <= st_nx;
    end

    // R4: the sequence only advances on a bus write
    assert_seq_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st));

    // R4: a wrong second unlock cycle drops back to read mode
    assert_bad_unlock_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st == D_U1 && !(adr_lo == ADR_SECOND && wdata == CODE_UNLK2))
        |=> st == D_IDLE);

    // R2: a finished sequence always leaves the decoder idle
    assert_ev_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (ev.prog || ev.chip || ev.sect) |=> st == D_IDLE);

endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine
    import nor_csm_pkg::*;
#(
    parameter int SEC_W     = 3,
    parameter int IDX_W     = 6,
    parameter int WIN_CYC   = 5000,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    input  logic [SEC_W-1:0]      sec_in,
    input  logic [IDX_W-1:0]      idx_in,
    input  logic [7:0]            old_data,
    input  cmd_ev_t               ev,
    output eng_st_t               st,
    output logic [(1<<SEC_W)-1:0] sel_mask,
    output logic [7:0]            pdata,
    output logic [IDX_W-1:0]      pidx,
    output logic                  fail,
    output logic                  prog_en,
    output logic                  zero_en,
    output logic                  ones_en
);
    localparam int SEC_N = 1 << SEC_W;
    localparam int MAXC  = max3(WIN_CYC, PROG_CYC, ERASE_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;
    ers_ph_t          ph;
    logic             susp_req;
    logic [SEC_N-1:0] sec_bit;

    assign susp_req = wr_en && (wdata == CODE_SUSP);
    assign sec_bit  = SEC_N'(1) << sec_in;

    assign prog_en = (st == E_PROG) && (cnt == '0);
    assign zero_en = (st == E_ERASE) && (cnt == '0) && !susp_req && (ph == PH_ZERO);
    assign ones_en = (st == E_ERASE) && (cnt == '0) && !susp_req && (ph == PH_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= E_IDLE;
            cnt      <= '0;
            ph       <= PH_ZERO;
            sel_mask <= '0;
            pdata    <= '0;
            pidx     <= '0;
            fail     <= 1'b0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (ev.prog) begin
                        st    <= E_PROG;
                        cnt   <= CNT_W'(PROG_CYC - 1);
                        pdata <= wdata;
                        pidx  <= idx_in;
                        fail  <= |(wdata & ~old_data);
                    end else if (ev.chip) begin
                        st       <= E_ERASE;
                        ph       <= PH_ZERO;
                        cnt      <= CNT_W'(ERASE_CYC - 1);
                        sel_mask <= '1;
                        fail     <= 1'b0;
                    end else if (ev.sect) begin
                        st       <= E_WIN;
                        cnt      <= CNT_W'(WIN_CYC - 1);
                        sel_mask <= sec_bit;
                        fail     <= 1'b0;
                    end
                end
                E_PROG: begin
                    if (cnt == '0) st  <= E_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                E_WIN: begin
                    if (wr_en && wdata == CODE_SECT) begin
                        sel_mask <= sel_mask | sec_bit;
                        cnt      <= CNT_W'(WIN_CYC - 1);
                    end else if (wr_en && wdata != CODE_SUSP) begin
                        st       <= E_IDLE;
                        sel_mask <= '0;
                    end else if (cnt == '0) begin
                        st  <= E_ERASE;
                        ph  <= PH_ZERO;
                        cnt <= CNT_W'(ERASE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_ERASE: begin
                    if (susp_req) begin
                        st <= E_SUSP;
                    end else if (cnt == '0) begin
                        if (ph == PH_ZERO) begin
                            ph  <= PH_ONES;
                            cnt <= CNT_W'(ERASE_CYC - 1);
                        end else begin
                            st       <= E_IDLE;
                            sel_mask <= '0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_SUSP: begin
                    if (wr_en && wdata == CODE_SECT) st <= E_ERASE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // R6: a busy program keeps its target and cannot be diverted by writes
    assert_prog_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (st == E_PROG) |=> ((st == E_PROG || st == E_IDLE) && $stable(pidx) && $stable(pdata)));

    // R10: a foreign command inside the window aborts to read mode
    assert_win_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (st == E_WIN && wr_en && wdata != CODE_SECT && wdata != CODE_SUSP)
        |=> (st == E_IDLE && sel_mask == '0));

    // R9: the erase set only grows while the window is open
    assert_mask_grow_R9: assert property (@(posedge clk) disable iff (rst)
        (st == E_WIN) |=> (st == E_IDLE || (sel_mask & $past(sel_mask)) == $past(sel_mask)));

    // R11: a suspended erase is frozen until the resume code
    assert_susp_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (st == E_SUSP && !(wr_en && wdata == CODE_SECT))
        |=> (st == E_SUSP && $stable(cnt) && $stable(ph) && $stable(sel_mask)));

endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int SEC_W = 3,
    parameter int OFS_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEC_W+OFS_W-1:0] look_idx,
    output logic [7:0]            look_data,
    input  logic                  prog_en,
    input  logic [SEC_W+OFS_W-1:0] prog_idx,
    input  logic [7:0]            prog_data,
    input  logic                  zero_en,
    input  logic                  ones_en,
    input  logic [(1<<SEC_W)-1:0] fill_mask
);
    localparam int IDX_W = SEC_W + OFS_W;
    localparam int WORDS = 1 << IDX_W;

    logic [7:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam int SEC_OF_G = g >> OFS_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= 8'hFF;
            end else if ((zero_en || ones_en) && fill_mask[SEC_OF_G]) begin
                mem_q[g] <= ones_en ? 8'hFF : 8'h00;
            end else if (prog_en && prog_idx == IDX_W'(g)) begin
                mem_q[g] <= mem_q[g] & prog_data;
            end
        end

        // R3: outside the set-to-ones erase phase no bit of a byte rises
        assert_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
            !ones_en |=> ((mem_q[g] & ~$past(mem_q[g])) == 8'h00));
    end

    assign look_data = mem_q[look_idx];

endmodule

// File: rtl/nor_flash_csm.sv
module nor_flash_csm
    import nor_csm_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int SEC_W     = 3,
    parameter int OFS_W     = 3,
    parameter int WIN_CYC   = 5000,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int SEC_N = 1 << SEC_W;
    localparam int IDX_W = SEC_W + OFS_W;

    eng_st_t          st;
    cmd_ev_t          ev;
    logic [SEC_N-1:0] sel_mask;
    logic [7:0]       pdata, look_data, status;
    logic [IDX_W-1:0] pidx, idx;
    logic [SEC_W-1:0] sec;
    logic             fail, prog_en, zero_en, ones_en;
    logic             tog, erase_like, busy, b2;
    logic             addr_unused_bits;

    assign sec = addr[ADDR_W-1 -: SEC_W];
    assign idx = {sec, addr[OFS_W-1:0]};
    assign addr_unused_bits = ^addr;

    nor_cmd_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en && st == E_IDLE),
        .adr_lo (addr[10:0]),
        .wdata  (wdata),
        .ev     (ev)
    );

    nor_op_engine #(
        .SEC_W     (SEC_W),
        .IDX_W     (IDX_W),
        .WIN_CYC   (WIN_CYC),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .sec_in   (sec),
        .idx_in   (idx),
        .old_data (look_data),
        .ev       (ev),
        .st       (st),
        .sel_mask (sel_mask),
        .pdata    (pdata),
        .pidx     (pidx),
        .fail     (fail),
        .prog_en  (prog_en),
        .zero_en  (zero_en),
        .ones_en  (ones_en)
    );

    nor_array #(
        .SEC_W (SEC_W),
        .OFS_W (OFS_W)
    ) u_arr (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (idx),
        .look_data (look_data),
        .prog_en   (prog_en),
        .prog_idx  (pidx),
        .prog_data (pdata),
        .zero_en   (zero_en),
        .ones_en   (ones_en),
        .fill_mask (sel_mask)
    );

    assign erase_like = (st == E_WIN) || (st == E_ERASE);
    assign busy       = erase_like || (st == E_PROG);
    assign b2         = (erase_like && sel_mask[sec]) ? tog : 1'b1;
    assign status     = { (st == E_PROG) ? ~pdata[7] : 1'b0,
                          tog,
                          (st == E_PROG) && fail,
                          1'b0,
                          st == E_ERASE,
                          b2,
                          2'b00 };

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= 8'h00;
            tog   <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= status;
                tog   <= ~tog;
            end else begin
                rdata <= look_data;
            end
        end
    end

    // R8: window reads show the timer as still running
    assert_win_b3_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && st == E_WIN) |=> (rdata[3] == 1'b0 && rdata[7] == 1'b0));

    // R7: erase reads show the timer as expired
    assert_ers_b3_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && st == E_ERASE) |=> (rdata[3] == 1'b1 && rdata[7] == 1'b0));

    // R5: back-to-back busy reads flip bit 6
    assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && $past(rd_en && busy)) |=> (rdata[6] != $past(rdata[6])));

endmodule

// File: tb/nor_flash_csm_tb.sv
module nor_flash_csm_tb;
    localparam int WIN  = 40;
    localparam int PRG  = 8;
    localparam int ERS  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    always #5 clk = ~clk;

    nor_flash_csm #(
        .ADDR_W(17), .SEC_W(3), .OFS_W(3),
        .WIN_CYC(WIN), .PROG_CYC(PRG), .ERASE_CYC(ERS)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    typedef struct {
        logic [7:0] e;
        logic [7:0] m;
        bit         t;
        string      tag;
    } item_t;

    item_t item_q[$];
    item_t mon_it;
    int    checks = 0;
    int    failures = 0;
    logic  rd_d = 1'b0;
    logic  last6 = 1'b0;

    always @(posedge clk) rd_d <= rd_en;

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        if (rd_d && item_q.size() > 0) begin
            mon_it = item_q.pop_front();
            checks++;
            if ((rdata & mon_it.m) !== (mon_it.e & mon_it.m)) begin
                failures++;
                $display("FAIL %s: got %02h exp %02h (mask %02h)",
                         mon_it.tag, rdata, mon_it.e, mon_it.m);
            end
            if (mon_it.t) begin
                checks++;
                if (rdata[6] === last6) begin
                    failures++;
                    $display("FAIL %s toggle: bit6 got %0b exp %0b",
                             mon_it.tag, rdata[6], ~last6);
                end
            end
            last6 = rdata[6];
        end
    end

    function automatic logic [16:0] sa(input int s, input int o);
        return {s[2:0], 14'(o)};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [16:0] a, input logic [7:0] e,
                      input logic [7:0] m, input bit t, input string tag);
        item_q.push_back('{e, m, t, tag});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
    endtask

    task automatic prog(input logic [16:0] a, input logic [7:0] d);
        unlock();
        wr(17'h00555, 8'hA0);
        wr(a, d);
    endtask

    task automatic ers_head();
        unlock();
        wr(17'h00555, 8'h80);
        unlock();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: erased state after reset
        rd(sa(0, 0), 8'hFF, 8'hFF, 0, "R1 reset s0");
        rd(sa(7, 5), 8'hFF, 8'hFF, 0, "R1 reset s7");

        // R2/R5: program, status polarity and toggle
        prog(sa(1, 1), 8'hF0);
        rd(sa(1, 1), 8'h04, 8'hBF, 0, "R5 prog status");
        rd(sa(1, 1), 8'h04, 8'hBF, 1, "R5 prog toggle");
        idle(PRG + 2);
        rd(sa(1, 1), 8'hF0, 8'hFF, 0, "R2 programmed");

        // R3: AND update and fail flag
        prog(sa(1, 1), 8'h3C);
        rd(sa(1, 1), 8'hA4, 8'hBF, 0, "R3 fail flag");
        idle(PRG + 2);
        rd(sa(1, 1), 8'h30, 8'hFF, 0, "R3 and result");

        // R6: writes ignored while programming
        prog(sa(2, 2), 8'h55);
        prog(sa(2, 3), 8'h00);
        idle(PRG + 2);
        rd(sa(2, 2), 8'h55, 8'hFF, 0, "R6 target");
        rd(sa(2, 3), 8'hFF, 8'hFF, 0, "R6 ignored");

        // R5: exact end of busy period
        prog(sa(3, 0), 8'h7E);
        idle(PRG - 2);
        rd(sa(3, 0), 8'h84, 8'hBF, 0, "R5 busy last-1");
        rd(sa(3, 0), 8'h84, 8'hBF, 1, "R5 busy last");
        rd(sa(3, 0), 8'h7E, 8'hFF, 0, "R5 released");

        // R4: broken sequence has no effect
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h54);
        wr(17'h00555, 8'hA0);
        wr(sa(4, 0), 8'h00);
        rd(sa(4, 0), 8'hFF, 8'hFF, 0, "R4 mismatch now");
        idle(PRG + 2);
        rd(sa(4, 0), 8'hFF, 8'hFF, 0, "R4 mismatch later");

        // R13: aliasing of unused address bits
        rd(sa(1, 1) | 17'h00800, 8'h30, 8'hFF, 0, "R13 alias mid");
        rd(sa(1, 9), 8'h30, 8'hFF, 0, "R13 alias ofs");

        // R8/R9/R12: sector erase with window
        prog(sa(5, 1), 8'h11);
        idle(PRG + 2);
        prog(sa(6, 1), 8'h22);
        idle(PRG + 2);
        ers_head();
        wr(sa(1, 0), 8'h30);
        rd(sa(1, 1), 8'h00, 8'hBB, 0, "R8 window b3");
        rd(sa(1, 1), 8'h00, 8'hBB, 1, "R12 window toggle");
        rd(sa(5, 1), 8'h04, 8'hBF, 0, "R12 unselected b2");
        idle(20);
        wr(sa(6, 0), 8'h30);
        idle(30);
        rd(sa(1, 1), 8'h00, 8'hBB, 0, "R9 window restarted");
        idle(12);
        rd(sa(1, 1), 8'h08, 8'hBB, 0, "R8 erase b3");
        rd(sa(5, 1), 8'h0C, 8'hBF, 0, "R12 erase unselected");
        idle(2 * ERS + 5);
        rd(sa(1, 1), 8'hFF, 8'hFF, 0, "R9 s1 erased");
        rd(sa(6, 1), 8'hFF, 8'hFF, 0, "R9 s6 erased");
        rd(sa(5, 1), 8'h11, 8'hFF, 0, "R9 s5 kept");
        rd(sa(3, 0), 8'h7E, 8'hFF, 0, "R13 read mode after erase");

        // R10: abort inside window
        ers_head();
        wr(sa(5, 0), 8'h30);
        wr(sa(5, 0), 8'hF0);
        rd(sa(5, 1), 8'h11, 8'hFF, 0, "R10 abort now");
        idle(WIN + 2 * ERS + 5);
        rd(sa(5, 1), 8'h11, 8'hFF, 0, "R10 abort later");

        // R7/R11: chip erase with suspend in the ones phase
        ers_head();
        wr(17'h00555, 8'h10);
        rd(sa(5, 1), 8'h08, 8'hBB, 0, "R7 chip status");
        idle(ERS + 2);
        wr(sa(0, 0), 8'hB0);
        rd(sa(5, 1), 8'h00, 8'hFF, 0, "R11 susp pre-zero");
        idle(40);
        rd(sa(3, 0), 8'h00, 8'hFF, 0, "R11 susp frozen");
        prog(sa(3, 0), 8'h00);
        wr(sa(0, 0), 8'h30);
        rd(sa(5, 1), 8'h08, 8'hBB, 0, "R11 resumed");
        idle(ERS + 5);
        rd(sa(5, 1), 8'hFF, 8'hFF, 0, "R7 s5 erased");
        rd(sa(3, 0), 8'hFF, 8'hFF, 0, "R7 s3 erased");
        rd(sa(2, 2), 8'hFF, 8'hFF, 0, "R7 s2 erased");

        idle(4);
        summary();
        $finish;
    end

endmodule